// File: doc/BRIEF.md
# Dual-Bank Operand Register File

This block holds the operands that the register select stage of a processor pipeline reads. Internally it keeps two banks of equal size. One is an integer bank and the other a floating-point bank. A single request reads three registers at once, and a per-request access code chooses which bank supplies all three. The read data is registered, so each value appears on the outputs one clock after the request.

Write-back owns a single write port. Each write carries a bank select bit, so a completing instruction updates either the integer bank or the floating-point bank. When a write and a read target the same register in the same cycle, the read returns the value being written.

Integer register zero is hard-wired to zero. Floating-point register zero is an ordinary register. When a request carries no access, the three outputs keep their last values.

Top module: `regfile_dual3r`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every register in both banks and drives all three read outputs to zero.
- R2: An access code of 2'b01 on rd_acc reads the integer bank. The data for each address appears on its output after the next rising clock edge and not before.
- R3: An access code of 2'b10 on rd_acc reads the floating-point bank, with the same one-cycle latency.
- R4: The three read ports take independent addresses and are served in the same request, including the case where all three name the same register.
- R5: A write with wr_bank = 0 updates only the integer bank, and a write with wr_bank = 1 updates only the floating-point bank. The register with the same address in the other bank keeps its value.
- R6: A read of integer register 0 always returns zero, and writes to integer register 0 have no effect.
- R7: Floating-point register 0 stores and returns written data like any other register.
- R8: An access code of 2'b00 or 2'b11 leaves all three read outputs unchanged on the next edge.
- R9: When a read and a write name the same bank and address in the same cycle, the read output returns the newly written data (write-first). Integer register 0 is the exception: it still returns zero.
- R10: A same-cycle write to the same address in the other bank does not forward into the read output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_acc | input | 2 | Access code: 01 integer, 10 floating-point, 00/11 none |
| rd_addr_a | input | 5 | Address for read port A |
| rd_addr_b | input | 5 | Address for read port B |
| rd_addr_c | input | 5 | Address for read port C |
| wr_en | input | 1 | Write strobe from write-back |
| wr_bank | input | 1 | Write bank: 0 integer, 1 floating-point |
| wr_addr | input | 5 | Write address |
| wr_data | input | 64 | Write data |
| rd_data_a | output | 64 | Registered read data, port A |
| rd_data_b | output | 64 | Registered read data, port B |
| rd_data_c | output | 64 | Registered read data, port C |

## Verification
A write from write-back and a three-port read can land in the same cycle. The bench forces this collision in three forms: same bank and same address, same address in the other bank, and integer register 0. For each form it compares the registered outputs against the write-first rule. A second overlap is a write that arrives while the access code is idle. Here the bench checks that the outputs hold their old values, and that a later read sees the stored data.

// File: rtl/rf_dual3r_pkg.sv
package rf_dual3r_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_INT  = 2'b01,
      ACC_FP   = 2'b10,
      ACC_RSVD = 2'b11
   } rf_acc_e;

   localparam logic BANK_INT = 1'b0;
   localparam logic BANK_FP  = 1'b1;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DEPTH     = 32,
   parameter int DATA_W    = 64,
   parameter int NRD       = 3,
   parameter bit ZERO_REG0 = 1'b0,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [AW-1:0]               waddr,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [NRD-1:0][AW-1:0]      raddr,
   output logic [NRD-1:0][DATA_W-1:0]  rdata
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic              we_eff;

   generate
      if (ZERO_REG0) begin : g_zero_wr
         assign we_eff = we && (waddr != '0);
      end else begin : g_plain_wr
         assign we_eff = we;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_eff) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      if (ZERO_REG0) begin : g_zero_rd
         assign rdata[p] = (raddr[p] == '0) ? '0 : mem[raddr[p]];
      end else begin : g_plain_rd
         assign rdata[p] = mem[raddr[p]];
      end
   end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
   import rf_dual3r_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int AW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rf_acc_e           acc,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] int_q,
   input  logic [DATA_W-1:0] fp_q,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   logic              hit_int, hit_fp, load;
   logic [DATA_W-1:0] nxt;

   assign hit_int = wr_en && (wr_bank == BANK_INT) && (wr_addr == addr) && (addr != '0);
   assign hit_fp  = wr_en && (wr_bank == BANK_FP)  && (wr_addr == addr);

   always_comb begin
      load = 1'b0;
      nxt  = q;
      unique case (acc)
         ACC_INT: begin
            load = 1'b1;
            nxt  = hit_int ? wr_data : int_q;
         end
         ACC_FP: begin
            load = 1'b1;
            nxt  = hit_fp ? wr_data : fp_q;
         end
         default: begin
            load = 1'b0;
            nxt  = q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= nxt;
   end
endmodule

// File: rtl/regfile_dual3r.sv
module regfile_dual3r
   import rf_dual3r_pkg::*;
#(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 64,
   localparam int AW    = $clog2(DEPTH),
   localparam int NRD   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        rd_acc,
   input  logic [AW-1:0]     rd_addr_a,
   input  logic [AW-1:0]     rd_addr_b,
   input  logic [AW-1:0]     rd_addr_c,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [DATA_W-1:0] rd_data_c
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("regfile_dual3r: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("regfile_dual3r: DATA_W must be positive");
   end

   rf_acc_e                     acc;
   logic [NRD-1:0][AW-1:0]      raddr;
   logic [NRD-1:0][DATA_W-1:0]  int_q, fp_q, port_q;

   assign acc   = rf_acc_e'(rd_acc);
   assign raddr = {rd_addr_c, rd_addr_b, rd_addr_a};

   rf_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD), .ZERO_REG0(1'b1)) u_int_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_bank == BANK_INT)), .waddr(wr_addr), .wdata(wr_data),
      .raddr(raddr), .rdata(int_q)
   );

   rf_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD), .ZERO_REG0(1'b0)) u_fp_bank (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (wr_bank == BANK_FP)), .waddr(wr_addr), .wdata(wr_data),
      .raddr(raddr), .rdata(fp_q)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_port
      rf_read_port #(.DATA_W(DATA_W), .AW(AW)) u_rp (
         .clk(clk), .rst_n(rst_n), .acc(acc), .addr(raddr[p]),
         .int_q(int_q[p]), .fp_q(fp_q[p]),
         .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
         .q(port_q[p])
      );
   end

   assign rd_data_a = port_q[0];
   assign rd_data_b = port_q[1];
   assign rd_data_c = port_q[2];
endmodule

// File: rtl/rf_dual3r_chk.sv
module rf_dual3r_chk #(
   parameter int DATA_W = 64,
   parameter int AW     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        rd_acc,
   input logic [AW-1:0]     rd_addr_a,
   input logic [AW-1:0]     rd_addr_b,
   input logic [AW-1:0]     rd_addr_c,
   input logic              wr_en,
   input logic              wr_bank,
   input logic [AW-1:0]     wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [DATA_W-1:0] rd_data_b,
   input logic [DATA_W-1:0] rd_data_c
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (rd_data_a == '0 && rd_data_b == '0 && rd_data_c == '0)); // R1

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc == 2'b00 || rd_acc == 2'b11) |=>
         ($stable(rd_data_a) && $stable(rd_data_b) && $stable(rd_data_c))); // R8

   AST_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc == 2'b01 && rd_addr_c == '0) |=> (rd_data_c == '0)); // R6

   AST_WRITE_FIRST_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc == 2'b01 && wr_en && !wr_bank && wr_addr == rd_addr_a && rd_addr_a != '0)
         |=> (rd_data_a == $past(wr_data))); // R9

   AST_WRITE_FIRST_FP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc == 2'b10 && wr_en && wr_bank && wr_addr == rd_addr_b)
         |=> (rd_data_b == $past(wr_data))); // R9
endmodule

bind regfile_dual3r rf_dual3r_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc),
   .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_addr_c(rd_addr_c),
   .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c)
);

// File: tb/tb_regfile_dual3r.sv
`timescale 1ns/1ps
module tb_regfile_dual3r;
   localparam int DW = 64;
   localparam int AW = 5;

   typedef struct packed {
      logic          we;
      logic          wb;
      logic [AW-1:0] wa;
      logic [DW-1:0] wd;
      logic [1:0]    acc;
      logic [AW-1:0] a, b, c;
      logic [DW-1:0] ea, eb, ec;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 5'd5,  64'hA5,   2'b00, 5'd5,  5'd5, 5'd5,  64'h0,  64'h0,  64'h0,  8'd8},  // R8 write while idle
      '{1'b1, 1'b1, 5'd5,  64'hF5,   2'b01, 5'd5,  5'd0, 5'd5,  64'hA5, 64'h0,  64'hA5, 8'd2},  // R2 R5
      '{1'b1, 1'b0, 5'd0,  64'hDEAD, 2'b01, 5'd0,  5'd5, 5'd0,  64'h0,  64'hA5, 64'h0,  8'd6},  // R6
      '{1'b1, 1'b1, 5'd0,  64'hF0,   2'b10, 5'd5,  5'd0, 5'd1,  64'hF5, 64'hF0, 64'h0,  8'd3},  // R3 R7 R9
      '{1'b0, 1'b0, 5'd0,  64'h0,    2'b10, 5'd0,  5'd5, 5'd0,  64'hF0, 64'hF5, 64'hF0, 8'd7},  // R7
      '{1'b1, 1'b0, 5'd7,  64'h77,   2'b01, 5'd7,  5'd7, 5'd5,  64'h77, 64'h77, 64'hA5, 8'd9},  // R9
      '{1'b1, 1'b1, 5'd9,  64'h99,   2'b01, 5'd9,  5'd5, 5'd7,  64'h0,  64'hA5, 64'h77, 8'd10}, // R10
      '{1'b1, 1'b0, 5'd3,  64'h33,   2'b11, 5'd3,  5'd3, 5'd3,  64'h0,  64'hA5, 64'h77, 8'd8},  // R8 code 11
      '{1'b0, 1'b0, 5'd0,  64'h0,    2'b00, 5'd1,  5'd2, 5'd3,  64'h0,  64'hA5, 64'h77, 8'd8},  // R8 code 00
      '{1'b0, 1'b0, 5'd0,  64'h0,    2'b10, 5'd9,  5'd3, 5'd5,  64'h99, 64'h0,  64'hF5, 8'd5},  // R5
      '{1'b0, 1'b0, 5'd0,  64'h0,    2'b01, 5'd3,  5'd9, 5'd0,  64'h33, 64'h0,  64'h0,  8'd4},  // R4
      '{1'b1, 1'b0, 5'd31, 64'h1F,   2'b01, 5'd31, 5'd31, 5'd3, 64'h1F, 64'h1F, 64'h33, 8'd9}   // R9 top address
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    rd_acc = 2'b00;
   logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, rd_addr_c = '0;
   logic          wr_en = 1'b0, wr_bank = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data_a, rd_data_b, rd_data_c;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   regfile_dual3r dut (
      .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc),
      .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_addr_c(rd_addr_c),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic wb, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic [1:0] acc,
                        input logic [AW-1:0] a, input logic [AW-1:0] b, input logic [AW-1:0] c);
      @(negedge clk);
      wr_en = we; wr_bank = wb; wr_addr = wa; wr_data = wd;
      rd_acc = acc; rd_addr_a = a; rd_addr_b = b; rd_addr_c = c;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_acc = 2'b00;
   endtask

   initial begin : watchdog
      #50000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      check("R1", "reset a", rd_data_a, '0);
      check("R1", "reset b", rd_data_b, '0);
      check("R1", "reset c", rd_data_c, '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VECS[i].req);
         drive(VECS[i].we, VECS[i].wb, VECS[i].wa, VECS[i].wd,
               VECS[i].acc, VECS[i].a, VECS[i].b, VECS[i].c);
         check(tag, $sformatf("vec %0d a", i), rd_data_a, VECS[i].ea);
         check(tag, $sformatf("vec %0d b", i), rd_data_b, VECS[i].eb);
         check(tag, $sformatf("vec %0d c", i), rd_data_c, VECS[i].ec);
      end

      // R2: request applied, output not yet changed before the edge
      @(negedge clk);
      rd_acc = 2'b01; rd_addr_a = 5'd7; rd_addr_b = 5'd7; rd_addr_c = 5'd7;
      #1;
      check("R2", "before edge", rd_data_a, 64'h1F);
      @(posedge clk);
      #1;
      check("R2", "after edge", rd_data_a, 64'h77);
      rd_acc = 2'b00;

      // R1: mid-run reset clears outputs and storage
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", "async clear a", rd_data_a, '0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, '0, '0, 2'b01, 5'd5, 5'd7, 5'd31);
      check("R1", "int cleared a", rd_data_a, '0);
      check("R1", "int cleared b", rd_data_b, '0);
      check("R1", "int cleared c", rd_data_c, '0);
      drive(1'b0, 1'b0, '0, '0, 2'b10, 5'd0, 5'd5, 5'd9);
      check("R1", "fp cleared a", rd_data_a, '0);
      check("R1", "fp cleared b", rd_data_b, '0);
      check("R1", "fp cleared c", rd_data_c, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule